// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the hardware half of a receive descriptor ring. Software prepares descriptors in a small internal descriptor memory. Each descriptor holds a status halfword, a length halfword and a buffer pointer. Software hands a descriptor to the engine by setting its empty flag. It then arms the engine through a write to the activate register. Frames arrive as a byte stream with valid/ready handshaking plus last and error markers. The engine places the bytes of each frame at the buffer pointer of the current descriptor through a byte write port. It then writes back the length and status, clears the empty flag and moves on to the next descriptor.

The ring does not have a fixed size. The engine returns to the ring start after any descriptor whose wrap flag is set, and it also returns to index 0 after the last memory slot. The ring start is set by a start register write. When the engine finds that the current descriptor is not empty, it stops polling. It resumes only after the next activate write.

A frame that cannot be placed is still accepted from the stream and discarded, and a drop counter is incremented. Back-pressure is simple: `in_ready` falls for exactly one cycle after each placed frame, while the descriptor is written back. At all other times it is high. A beat transfers only when `in_valid` and `in_ready` are both high. The source must hold its data, last and error values until that happens.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, `rx_active` is 0, `drop_count` is 0, `buf_we` is 0 and `in_ready` is 1.
- R2: A write on `kick_we` with `kick_data` bit 24 set makes `rx_active` 1. A write with bit 24 clear has no effect.
- R3: When a frame starts while active and the current descriptor is empty, byte k of the frame is written to address buffer pointer + k. A byte is written only on an accepted beat.
- R4: Descriptor d occupies word 2d, laid out as {status[15:0], length[15:0]}, and word 2d+1, which holds the buffer pointer. On write-back, the length counts every stream byte, frame check sequence included. In the status, the empty bit (15) is cleared, the last bit (11) is set and the wrap bit (13) is kept.
- R5: After write-back the engine moves to the next descriptor. After a descriptor with the wrap bit set, it returns to the ring start.
- R6: While active and idle, if the current descriptor has its empty bit clear, `rx_active` clears.
- R7: A frame that begins while inactive, or while the current descriptor is not empty, is fully accepted and discarded. `drop_count` increases by exactly 1 at its last beat, and no memory is written.
- R8: At most BUF_BYTES bytes are stored and the written length is the stored count. When the frame exceeds MAX_FRAME bytes, status bit 5 is set.
- R9: If `in_err` is high on any accepted beat of a placed frame, status bit 1 is set. A nonzero value in status bits 5..0 marks a bad frame.
- R10: `in_ready` is 0 for exactly the one write-back cycle after the last beat of a placed frame.
- R11: A write on `start_we` sets both the ring start and the current descriptor to `start_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we | input | 1 | Software descriptor word write |
| sw_addr | input | IW+1 | Descriptor memory word index |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Descriptor word at sw_addr (combinational) |
| start_we | input | 1 | Ring start register write |
| start_idx | input | IW | Ring start descriptor index |
| kick_we | input | 1 | Activate register write |
| kick_data | input | 32 | Activate write value (bit 24 arms) |
| rx_active | output | 1 | Engine polling descriptors |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_err | input | 1 | Receive error on this byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| drop_count | output | CNT_W | Dropped frame count |

## Verification
The bench builds the engine with four descriptors, a 12-byte buffer limit and a 10-byte frame limit. With these values, truncation and the length-violation bit are reached with a 15-byte frame, and a three-descriptor ring with a wrap bit can be walked in a few frames. Besides wrapping, the bench also re-arms a used slot and moves the start register, so both ways of choosing the next descriptor are exercised.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int ST_EMPTY  = 15;
  localparam int ST_WRAP   = 13;
  localparam int ST_LAST   = 11;
  localparam int ST_LENVIO = 5;
  localparam int ST_RXERR  = 1;
  localparam int ARM_BIT   = 24;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_WB, S_DROP} state_e;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int NUM_DESC = 8,
  localparam int IW = $clog2(NUM_DESC),
  localparam int AW = IW + 1,
  localparam int WORDS = 2 * NUM_DESC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_addr,
  input  logic [31:0]   sw_wdata,
  output logic [31:0]   sw_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [31:0]   eng_wdata,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_ctl,
  output logic [31:0]   rd_ptr
);
  logic [31:0] view [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (eng_we && eng_addr == AW'(w))
        word_q <= eng_wdata;
      else if (sw_we && sw_addr == AW'(w))
        word_q <= sw_wdata;
    end
    assign view[w] = word_q;
  end

  assign sw_rdata = view[sw_addr];
  assign rd_ctl   = view[{rd_idx, 1'b0}];
  assign rd_ptr   = view[{rd_idx, 1'b1}];
endmodule

// File: rtl/rxr_len_track.sv
module rxr_len_track #(
  parameter int BUF_BYTES = 1520,
  parameter int MAX_FRAME = 1518,
  localparam int CW = $clog2(BUF_BYTES + MAX_FRAME + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first,
  input  logic          beat,
  output logic [CW-1:0] stored,
  output logic          room,
  output logic          over
);
  logic [CW-1:0] total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored  <= '0;
      total_q <= '0;
    end else if (first) begin
      stored  <= CW'(1);
      total_q <= CW'(1);
    end else if (beat) begin
      if (room) stored <= stored + CW'(1);
      if (total_q <= CW'(MAX_FRAME)) total_q <= total_q + CW'(1);
    end
  end

  assign room = stored < CW'(BUF_BYTES);
  assign over = total_q > CW'(MAX_FRAME);
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int NUM_DESC  = 8,
  parameter int BUF_BYTES = 1520,
  parameter int MAX_FRAME = 1518,
  parameter int CNT_W     = 16,
  localparam int IW = $clog2(NUM_DESC),
  localparam int AW = IW + 1,
  localparam int CW = $clog2(BUF_BYTES + MAX_FRAME + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [AW-1:0]    sw_addr,
  input  logic [31:0]      sw_wdata,
  output logic [31:0]      sw_rdata,
  input  logic             start_we,
  input  logic [IW-1:0]    start_idx,
  input  logic             kick_we,
  input  logic [31:0]      kick_data,
  output logic             rx_active,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             in_err,
  output logic             buf_we,
  output logic [31:0]      buf_addr,
  output logic [7:0]       buf_data,
  output logic [CNT_W-1:0] drop_count
);
  import rxr_pkg::*;

  state_e        state_q;
  logic [IW-1:0] cur_q, base_q, cur_next;
  logic          active_q, err_q;
  logic [31:0]   rd_ctl, rd_ptr, wb_word;
  logic [15:0]   status, wb_status;
  logic          accept, start_frame, take, beat, room, over;
  logic [CW-1:0] stored;

  assign status      = rd_ctl[31:16];
  assign in_ready    = (state_q != S_WB);
  assign accept      = in_valid && in_ready;
  assign start_frame = (state_q == S_IDLE) && accept;
  assign take        = start_frame && active_q && status[ST_EMPTY];
  assign beat        = (state_q == S_RECV) && accept;

  assign buf_we   = take || (beat && room);
  assign buf_addr = rd_ptr + (take ? 32'd0 : 32'(stored));
  assign buf_data = in_data;

  always_comb begin
    wb_status            = '0;
    wb_status[ST_WRAP]   = status[ST_WRAP];
    wb_status[ST_LAST]   = 1'b1;
    wb_status[ST_LENVIO] = over;
    wb_status[ST_RXERR]  = err_q;
  end
  assign wb_word = {wb_status, 16'(stored)};

  always_comb begin
    if (status[ST_WRAP])
      cur_next = base_q;
    else if (cur_q == IW'(NUM_DESC - 1))
      cur_next = '0;
    else
      cur_next = cur_q + IW'(1);
  end

  rxr_desc_mem #(.NUM_DESC(NUM_DESC)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .eng_we(state_q == S_WB), .eng_addr({cur_q, 1'b0}), .eng_wdata(wb_word),
    .rd_idx(cur_q), .rd_ctl(rd_ctl), .rd_ptr(rd_ptr)
  );

  rxr_len_track #(.BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME)) u_len (
    .clk(clk), .rst_n(rst_n), .first(take), .beat(beat),
    .stored(stored), .room(room), .over(over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      cur_q      <= '0;
      base_q     <= '0;
      active_q   <= 1'b0;
      err_q      <= 1'b0;
      drop_count <= '0;
    end else begin
      if (state_q == S_IDLE && active_q && !status[ST_EMPTY])
        active_q <= 1'b0;
      if (kick_we && kick_data[ARM_BIT])
        active_q <= 1'b1;

      case (state_q)
        S_IDLE: begin
          if (take) begin
            err_q   <= in_err;
            state_q <= in_last ? S_WB : S_RECV;
          end else if (start_frame) begin
            if (in_last) drop_count <= drop_count + CNT_W'(1);
            else         state_q    <= S_DROP;
          end
        end
        S_RECV: begin
          if (accept) begin
            err_q <= err_q | in_err;
            if (in_last) state_q <= S_WB;
          end
        end
        S_WB: begin
          cur_q   <= cur_next;
          state_q <= S_IDLE;
        end
        default: begin
          if (accept && in_last) begin
            drop_count <= drop_count + CNT_W'(1);
            state_q    <= S_IDLE;
          end
        end
      endcase

      if (start_we) begin
        base_q <= start_idx;
        cur_q  <= start_idx;
      end
    end
  end

  assign rx_active = active_q;
endmodule

// File: rtl/rxr_checker.sv
module rxr_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_active,
  input logic             kick_we,
  input logic [31:0]      kick_data,
  input logic             in_valid,
  input logic             in_ready,
  input logic             buf_we,
  input logic [CNT_W-1:0] drop_count,
  input rxr_pkg::state_e  state_q
);
  // R2
  arm_by_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(kick_we && kick_data[24]));

  // R6
  stop_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_active) |-> $past(state_q == rxr_pkg::S_IDLE));

  // R3
  write_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> (in_valid && in_ready));

  // R10
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R7
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + CNT_W'(1)));
endmodule

bind rx_ring_engine rxr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_active(rx_active), .kick_we(kick_we),
  .kick_data(kick_data), .in_valid(in_valid), .in_ready(in_ready),
  .buf_we(buf_we), .drop_count(drop_count), .state_q(state_q)
);

// File: tb/rx_ring_engine_bench.sv
module rx_ring_engine_bench;
  localparam int ND = 4;
  localparam int BB = 12;
  localparam int MF = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_we = 1'b0;
  logic [2:0]  sw_addr = '0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;
  logic        start_we = 1'b0;
  logic [1:0]  start_idx = '0;
  logic        kick_we = 1'b0;
  logic [31:0] kick_data = '0;
  logic        rx_active;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_err = 1'b0;
  logic        buf_we;
  logic [31:0] buf_addr;
  logic [7:0]  buf_data;
  logic [15:0] drop_count;

  int tests = 0;
  int fails = 0;
  logic [7:0] bmem [256];

  always #4 clk = ~clk;

  rx_ring_engine #(.NUM_DESC(ND), .BUF_BYTES(BB), .MAX_FRAME(MF)) u_rx_ring_engine (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .start_we(start_we), .start_idx(start_idx),
    .kick_we(kick_we), .kick_data(kick_data), .rx_active(rx_active),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .in_err(in_err), .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .drop_count(drop_count)
  );

  always @(posedge clk) if (buf_we) bmem[buf_addr[7:0]] <= buf_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); sw_we = 1'b1; sw_addr = a; sw_wdata = d;
    @(posedge clk); #1 sw_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); sw_addr = a; #1 d = sw_rdata;
  endtask

  task automatic kick(input logic [31:0] v);
    @(negedge clk); kick_we = 1'b1; kick_data = v;
    @(posedge clk); #1 kick_we = 1'b0;
  endtask

  task automatic send(input int n, input int err_at, input logic [7:0] b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = b + 8'(i); in_last = (i == n - 1); in_err = (i == err_at);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0; in_err = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 active", 32'(rx_active), 32'd0);
    check("R1 drops", 32'(drop_count), 32'd0);
    check("R1 buf_we", 32'(buf_we), 32'd0);
    check("R1 ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_kick_ignored();
    logic [31:0] w;
    kick(32'h0000_0001);
    @(negedge clk);
    check("R2 no arm", 32'(rx_active), 32'd0);
    send(3, -1, 8'h01);
    repeat (2) @(negedge clk);
    check("R7 drop inactive", 32'(drop_count), 32'd1);
    rd(3'd0, w);
    check("R7 desc untouched", w, 32'h8000_0000);
    check("R7 no byte", 32'(bmem[0]), 32'd0);
  endtask

  task automatic t_first_frame();
    logic [31:0] w;
    kick(32'h0100_0000);
    @(negedge clk);
    check("R2 armed", 32'(rx_active), 32'd1);
    send(5, -1, 8'h10);
    check("R10 stall", 32'(in_ready), 32'd0);
    @(negedge clk);
    check("R10 release", 32'(in_ready), 32'd1);
    rd(3'd0, w);
    check("R4 writeback", w, 32'h0800_0005);
    check("R3 byte0", 32'(bmem[0]), 32'h10);
    check("R3 byte4", 32'(bmem[4]), 32'h14);
    check("R3 past end", 32'(bmem[5]), 32'd0);
  endtask

  task automatic t_error_frame();
    logic [31:0] w;
    send(4, 1, 8'h40);
    repeat (2) @(negedge clk);
    rd(3'd2, w);
    check("R9 error bit", w, 32'h0802_0004);
    check("R5 next buffer", 32'(bmem[32]), 32'h40);
    check("R5 next buffer end", 32'(bmem[35]), 32'h43);
  endtask

  task automatic t_oversize_wrap();
    logic [31:0] w;
    send(15, -1, 8'h80);
    repeat (2) @(negedge clk);
    rd(3'd4, w);
    check("R8 truncate status", w, 32'h2820_000C);
    check("R8 last stored", 32'(bmem[75]), 32'h8B);
    check("R8 not stored", 32'(bmem[76]), 32'd0);
    check("R6 stop on full", 32'(rx_active), 32'd0);
  endtask

  task automatic t_no_empty();
    logic [31:0] w;
    kick(32'h0100_0000);
    repeat (2) @(negedge clk);
    check("R6 stop after kick", 32'(rx_active), 32'd0);
    send(4, -1, 8'hE0);
    repeat (2) @(negedge clk);
    check("R7 drop full", 32'(drop_count), 32'd2);
    rd(3'd0, w);
    check("R7 desc kept", w, 32'h0800_0005);
    check("R7 buffer kept", 32'(bmem[0]), 32'h10);
  endtask

  task automatic t_wrap_restart();
    logic [31:0] w;
    wr(3'd0, 32'h8000_0000);
    kick(32'h0100_0000);
    send(2, -1, 8'hC0);
    repeat (2) @(negedge clk);
    rd(3'd0, w);
    check("R5 wrap to start", w, 32'h0800_0002);
    check("R5 wrap data", 32'(bmem[0]), 32'hC0);
  endtask

  task automatic t_start_reg();
    logic [31:0] w;
    wr(3'd6, 32'h8000_0000);
    @(negedge clk); start_we = 1'b1; start_idx = 2'd3;
    @(posedge clk); #1 start_we = 1'b0;
    kick(32'h0100_0000);
    send(3, -1, 8'hD0);
    repeat (2) @(negedge clk);
    rd(3'd6, w);
    check("R11 start desc", w, 32'h0800_0003);
    check("R11 start data", 32'(bmem[98]), 32'hD2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    wr(3'd0, 32'h8000_0000); wr(3'd1, 32'd0);
    wr(3'd2, 32'h8000_0000); wr(3'd3, 32'd32);
    wr(3'd4, 32'hA000_0000); wr(3'd5, 32'd64);
    wr(3'd6, 32'h0000_0000); wr(3'd7, 32'd96);
    t_kick_ignored();
    t_first_frame();
    t_error_frame();
    t_oversize_wrap();
    t_no_empty();
    t_wrap_restart();
    t_start_reg();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule